// File: doc/BRIEF.md
# Page-Mapped Flash Translation Controller

This block translates logical page numbers from a host into physical pages of a small modelled flash array of 4 erase blocks with 16 pages each. Pages hold a narrow payload. A page can only move its bits from one to zero, and erasing works only on a whole block. For these reasons a host write never updates a page in place. The data goes to the next erased page of the currently open block, the forward map is pointed at that page, and the page that held the older copy is marked stale. A reverse map records which logical page each physical page holds, so that live pages can be moved later.

Free space is reclaimed greedily. Among the fully programmed blocks, the one with the fewest live pages is chosen. Its live pages are copied into the open block one at a time, the forward map is updated for each copy, and the block is then erased. Two counters run side by side: one counts accepted host writes and the other counts every page program, including the copies. The ratio of the second to the first is the write amplification. Only 48 logical pages are exposed, so one block's worth of pages is always held back as spare room.

Top module: `ftl_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, both counters are 0, and `rsp_valid` and `gc_active` are 0.
- R2: A read of a mapped logical page returns the data of its most recent write, including after the page has been overwritten.
- R3: A read of a logical page that has never been written since reset returns 8'hFF with `rsp_unmapped` set to 1.
- R4: A request with `req_addr` of 48 or above is answered with `rsp_err` set to 1 and `rsp_rdata` equal to 8'hFF. It leaves both counters unchanged and changes no stored data.
- R5: `host_wr_cnt` increases by exactly one for each accepted write whose address is in range.
- R6: `prog_cnt` increases by exactly one for each page program, whether from the host or from a relocation copy. It therefore equals `host_wr_cnt` as long as no live page has been copied.
- R7: Reclamation starts when there are fewer than 16 erased pages in total and the erased-page count is no larger than the live-page count of the chosen victim. The victim is the fully programmed block (not the partly filled open block) with the fewest live pages, and the lowest block index wins a tie. Its live pages are copied in ascending page order. Starting from 48 fresh writes to logical pages 0..47, one rewrite of page 0 gives `host_wr_cnt` = 49 and `prog_cnt` = 64.
- R8: Every logical page reads back its latest data after any number of reclamations.
- R9: `req_ready` is 0 whenever `gc_active` is 1. `gc_active` is 1 throughout relocation and erase.
- R10: A read or rejected request is answered in the cycle after the accepting edge. An in-range write is answered `PROG_CYC` cycles after the accepting edge.
- R11: Reclaiming a block that holds no live pages performs no program. Four passes of writes over logical pages 0..15 end with both counters equal to 64, and one reclamation takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Logical page number (0..47 valid) |
| req_wdata | input | 8 | Write payload |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 8 | Read payload (8'hFF when unmapped or rejected) |
| rsp_err | output | 1 | Address out of range |
| rsp_unmapped | output | 1 | Read of a never-written page |
| gc_active | output | 1 | Reclamation in progress |
| host_wr_cnt | output | 32 | Accepted host writes |
| prog_cnt | output | 32 | Page programs including copies |

## Verification
The properties assume that request fields are only meaningful while `req_valid` is high. They also assume that the counters never wrap, which is what lets the ordering between program count and host count hold. The stimulus raises `req_valid` only at a falling edge where `req_ready` is already high, and holds it for a single cycle. It issues a few hundred requests, far below the counter limit. Exact counter values are predicted only for scenarios where the fill order fixes the victim choice: a fully live drive with one rewrite, and four passes over one block's worth of addresses. Other rewrite traffic is checked through read-back of every logical page.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

  typedef enum logic [1:0] {
    PG_ERASED = 2'd0,
    PG_LIVE   = 2'd1,
    PG_STALE  = 2'd2
  } pg_state_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBUSY,
    ST_SCAN,
    ST_CBUSY,
    ST_EBUSY
  } ctl_state_t;

  // Reclaim when spare room is under one block and no larger than what
  // the chosen victim would need for its live pages.
  function automatic logic reclaim_due(input int unsigned free_pg,
                                       input int unsigned victim_live,
                                       input int unsigned pages_per_blk,
                                       input logic        have_victim);
    return have_victim && (free_pg < pages_per_blk) && (free_pg <= victim_live);
  endfunction

endpackage

// File: rtl/ftl_page_store.sv
module ftl_page_store #(
  parameter int NBLK = 4,
  parameter int PPB  = 16,
  parameter int DW   = 8,
  localparam int NPAGE = NBLK * PPB,
  localparam int BW    = $clog2(NBLK),
  localparam int PW    = $clog2(PPB),
  localparam int PAW   = BW + PW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prog_en,
  input  logic [PAW-1:0] prog_pa,
  input  logic [DW-1:0]  prog_data,
  input  logic           erase_en,
  input  logic [BW-1:0]  erase_blk,
  input  logic [PAW-1:0] rd_pa,
  output logic [DW-1:0]  rd_data
);

  logic [DW-1:0] cells [NPAGE];

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    localparam logic [PAW-1:0] MY_PA  = PAW'(p);
    localparam logic [BW-1:0]  MY_BLK = BW'(p / PPB);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cells[p] <= '1;
      end else if (erase_en && erase_blk == MY_BLK) begin
        cells[p] <= '1;
      end else if (prog_en && prog_pa == MY_PA) begin
        cells[p] <= cells[p] & prog_data;   // bits only fall
      end
    end
  end

  assign rd_data = cells[rd_pa];

endmodule

// File: rtl/ftl_victim_sel.sv
module ftl_victim_sel #(
  parameter int NBLK = 4,
  parameter int PPB  = 16,
  localparam int NPAGE = NBLK * PPB,
  localparam int BW    = $clog2(NBLK),
  localparam int CW    = $clog2(PPB + 1),
  localparam int FW    = $clog2(NPAGE + 1)
) (
  input  logic [NPAGE-1:0] live_vec,
  input  logic [NPAGE-1:0] erased_vec,
  input  logic [BW-1:0]    open_blk,
  input  logic             open_full,
  output logic [BW-1:0]    victim_blk,
  output logic [CW-1:0]    victim_live,
  output logic             victim_ok,
  output logic [BW-1:0]    spare_blk,
  output logic             spare_ok,
  output logic [FW-1:0]    free_cnt
);

  logic [CW-1:0] n_live, n_erased;
  logic          is_open;

  always_comb begin
    victim_blk  = '0;
    victim_live = '1;
    victim_ok   = 1'b0;
    spare_blk   = '0;
    spare_ok    = 1'b0;
    free_cnt    = '0;
    n_live      = '0;
    n_erased    = '0;
    is_open     = 1'b0;
    for (int b = 0; b < NBLK; b++) begin
      n_live   = '0;
      n_erased = '0;
      for (int p = 0; p < PPB; p++) begin
        n_live   = n_live   + CW'(live_vec[b*PPB + p]);
        n_erased = n_erased + CW'(erased_vec[b*PPB + p]);
      end
      free_cnt = free_cnt + FW'(n_erased);
      if (n_erased == CW'(PPB) && !spare_ok) begin
        spare_ok  = 1'b1;
        spare_blk = BW'(b);
      end
      is_open = (BW'(b) == open_blk) && !open_full;
      if (n_erased == '0 && !is_open && (!victim_ok || n_live < victim_live)) begin
        victim_ok   = 1'b1;
        victim_blk  = BW'(b);
        victim_live = n_live;
      end
    end
  end

endmodule

// File: rtl/ftl_ctrl.sv
module ftl_ctrl
  import ftl_pkg::*;
#(
  parameter int NBLK      = 4,
  parameter int PPB       = 16,
  parameter int LPAGES    = 48,
  parameter int DW        = 8,
  parameter int PROG_CYC  = 2,
  parameter int ERASE_CYC = 4,
  parameter int CNTW      = 32,
  localparam int NPAGE = NBLK * PPB,
  localparam int BW    = $clog2(NBLK),
  localparam int PW    = $clog2(PPB),
  localparam int PAW   = BW + PW,
  localparam int CW    = $clog2(PPB + 1),
  localparam int FW    = $clog2(NPAGE + 1),
  localparam int TMAX  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int TW    = $clog2(TMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [PAW-1:0]  req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_err,
  output logic            rsp_unmapped,
  output logic            gc_active,
  output logic [CNTW-1:0] host_wr_cnt,
  output logic [CNTW-1:0] prog_cnt
);

  ctl_state_t     st;
  logic [TW-1:0]  tmr;
  logic [BW-1:0]  wr_blk, vic;
  logic [PW-1:0]  wr_pg, idx;
  logic           open_full;

  pg_state_t      pg_st [NPAGE];
  logic [PAW-1:0] l2p    [LPAGES];
  logic           l2p_ok [LPAGES];
  logic [PAW-1:0] p2l    [NPAGE];

  logic [NPAGE-1:0] live_vec, erased_vec;
  for (genvar p = 0; p < NPAGE; p++) begin : g_vec
    assign live_vec[p]   = (pg_st[p] == PG_LIVE);
    assign erased_vec[p] = (pg_st[p] == PG_ERASED);
  end

  logic [BW-1:0] victim_blk, spare_blk;
  logic [CW-1:0] victim_live;
  logic          victim_ok, spare_ok;
  logic [FW-1:0] free_cnt;

  ftl_victim_sel #(.NBLK(NBLK), .PPB(PPB)) u_sel (
    .live_vec(live_vec), .erased_vec(erased_vec),
    .open_blk(wr_blk), .open_full(open_full),
    .victim_blk(victim_blk), .victim_live(victim_live), .victim_ok(victim_ok),
    .spare_blk(spare_blk), .spare_ok(spare_ok), .free_cnt(free_cnt)
  );

  // Named internal events, brought out for the checker.
  logic           fire, addr_bad, wr_ok, scan_live, copy_evt, prog_evt, erase_evt;
  logic           gc_need, advance_evt;
  logic [PAW-1:0] lidx, scan_pa, dst_pa, dst_lid, rd_pa;
  logic [DW-1:0]  rd_data, prog_data;

  assign gc_need     = reclaim_due(32'(free_cnt), 32'(victim_live), PPB, victim_ok);
  assign advance_evt = (st == ST_IDLE) && open_full && spare_ok;
  assign req_ready   = (st == ST_IDLE) && !open_full && !gc_need;
  assign gc_active   = (st == ST_SCAN) || (st == ST_CBUSY) || (st == ST_EBUSY);

  assign fire      = req_valid && req_ready;
  assign addr_bad  = int'(req_addr) >= LPAGES;
  assign lidx      = addr_bad ? '0 : req_addr;
  assign wr_ok     = fire && req_write && !addr_bad;
  assign scan_pa   = {vic, idx};
  assign scan_live = (pg_st[scan_pa] == PG_LIVE);
  assign copy_evt  = (st == ST_SCAN) && scan_live && !open_full;
  assign prog_evt  = wr_ok || copy_evt;
  assign erase_evt = ((st == ST_SCAN) && !scan_live && idx == PW'(PPB-1)) ||
                     ((st == ST_CBUSY) && tmr == TW'(1) && idx == PW'(PPB-1));
  assign dst_pa    = {wr_blk, wr_pg};
  assign dst_lid   = wr_ok ? req_addr : p2l[scan_pa];
  assign rd_pa     = gc_active ? scan_pa : l2p[lidx];
  assign prog_data = wr_ok ? req_wdata : rd_data;

  ftl_page_store #(.NBLK(NBLK), .PPB(PPB), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .prog_en(prog_evt), .prog_pa(dst_pa), .prog_data(prog_data),
    .erase_en(erase_evt), .erase_blk(vic),
    .rd_pa(rd_pa), .rd_data(rd_data)
  );

  // Maps, page states and the write pointer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPAGE; p++) begin
        pg_st[p] <= PG_ERASED;
        p2l[p]   <= '0;
      end
      for (int l = 0; l < LPAGES; l++) begin
        l2p[l]    <= '0;
        l2p_ok[l] <= 1'b0;
      end
      wr_blk    <= '0;
      wr_pg     <= '0;
      open_full <= 1'b0;
    end else begin
      if (prog_evt) begin
        if (copy_evt)             pg_st[scan_pa]   <= PG_STALE;
        else if (l2p_ok[lidx])    pg_st[l2p[lidx]] <= PG_STALE;
        pg_st[dst_pa]   <= PG_LIVE;
        p2l[dst_pa]     <= dst_lid;
        l2p[dst_lid]    <= dst_pa;
        l2p_ok[dst_lid] <= 1'b1;
        if (wr_pg == PW'(PPB-1)) open_full <= 1'b1;
        else                     wr_pg     <= wr_pg + PW'(1);
      end
      if (erase_evt) begin
        for (int p = 0; p < PPB; p++) pg_st[{vic, PW'(p)}] <= PG_ERASED;
      end
      if (advance_evt) begin
        wr_blk    <= spare_blk;
        wr_pg     <= '0;
        open_full <= 1'b0;
      end
    end
  end

  // Sequencer and response.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      tmr          <= '0;
      vic          <= '0;
      idx          <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '1;
      rsp_err      <= 1'b0;
      rsp_unmapped <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (fire) begin
            rsp_err      <= addr_bad;
            rsp_unmapped <= 1'b0;
            rsp_rdata    <= '1;
            if (wr_ok) begin
              st  <= ST_WBUSY;
              tmr <= TW'(PROG_CYC);
            end else begin
              rsp_valid <= 1'b1;
              if (!addr_bad && !req_write) begin
                rsp_unmapped <= !l2p_ok[lidx];
                rsp_rdata    <= l2p_ok[lidx] ? rd_data : '1;
              end
            end
          end else if (!advance_evt && gc_need) begin
            st  <= ST_SCAN;
            vic <= victim_blk;
            idx <= '0;
          end
        end
        ST_WBUSY: begin
          if (tmr == TW'(1)) begin
            st        <= ST_IDLE;
            rsp_valid <= 1'b1;
          end else tmr <= tmr - TW'(1);
        end
        ST_SCAN: begin
          if (copy_evt) begin
            st  <= ST_CBUSY;
            tmr <= TW'(PROG_CYC);
          end else if (erase_evt) begin
            st  <= ST_EBUSY;
            tmr <= TW'(ERASE_CYC);
          end else if (!scan_live) begin
            idx <= idx + PW'(1);
          end
        end
        ST_CBUSY: begin
          if (erase_evt) begin
            st  <= ST_EBUSY;
            tmr <= TW'(ERASE_CYC);
          end else if (tmr == TW'(1)) begin
            st  <= ST_SCAN;
            idx <= idx + PW'(1);
          end else tmr <= tmr - TW'(1);
        end
        ST_EBUSY: begin
          if (tmr == TW'(1)) st <= ST_IDLE;
          else               tmr <= tmr - TW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Wear accounting.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_wr_cnt <= '0;
      prog_cnt    <= '0;
    end else begin
      if (wr_ok)    host_wr_cnt <= host_wr_cnt + CNTW'(1);
      if (prog_evt) prog_cnt    <= prog_cnt + CNTW'(1);
    end
  end

endmodule

// File: rtl/ftl_ctrl_chk.sv
module ftl_ctrl_chk #(
  parameter int LPAGES = 48,
  parameter int PAW    = 6,
  parameter int DW     = 8,
  parameter int CNTW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [PAW-1:0]  req_addr,
  input logic            rsp_valid,
  input logic [DW-1:0]   rsp_rdata,
  input logic            rsp_err,
  input logic            rsp_unmapped,
  input logic            gc_active,
  input logic [CNTW-1:0] host_wr_cnt,
  input logic [CNTW-1:0] prog_cnt,
  input logic            prog_evt,
  input logic            copy_evt,
  input logic            erase_evt
);

  logic acc, acc_bad;
  assign acc     = req_valid && req_ready;
  assign acc_bad = int'(req_addr) >= LPAGES;

  assert_ready_low_in_gc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gc_active |-> !req_ready);

  assert_prog_not_below_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_cnt >= host_wr_cnt);

  assert_reject_keeps_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_bad) |=> rsp_valid && rsp_err && $stable(host_wr_cnt) && $stable(prog_cnt));

  assert_host_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !acc_bad) |=> host_wr_cnt == $past(host_wr_cnt) + CNTW'(1));

  assert_prog_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_evt |=> prog_cnt == $past(prog_cnt) + CNTW'(1));

  assert_prog_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_evt |=> $stable(prog_cnt));

  assert_read_answer_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);

  assert_unmapped_all_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unmapped) |-> rsp_rdata == '1);

  assert_copy_erase_in_gc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_evt || erase_evt) |-> gc_active);

endmodule

bind ftl_ctrl ftl_ctrl_chk #(.LPAGES(LPAGES), .PAW(PAW), .DW(DW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_unmapped(rsp_unmapped),
  .gc_active(gc_active), .host_wr_cnt(host_wr_cnt), .prog_cnt(prog_cnt),
  .prog_evt(prog_evt), .copy_evt(copy_evt), .erase_evt(erase_evt)
);

// File: tb/test_ftl_ctrl.sv
module test_ftl_ctrl;

  localparam int PROG_CYC = 2;
  localparam int LPAGES   = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid, rsp_err, rsp_unmapped, gc_active;
  logic [7:0]  rsp_rdata;
  logic [31:0] host_wr_cnt, prog_cnt;

  always #4 clk = ~clk;   // 125 MHz

  ftl_ctrl #(.PROG_CYC(PROG_CYC)) i_ftl_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_unmapped(rsp_unmapped), .gc_active(gc_active),
    .host_wr_cnt(host_wr_cnt), .prog_cnt(prog_cnt)
  );

  typedef struct {
    bit       wr;
    int       addr;
    bit [7:0] data;
    bit       err;
    bit       unm;
    int       acc;
    int       lat;
  } exp_t;

  exp_t     sb[$];
  bit [7:0] mdl [LPAGES];
  bit       mdl_ok [LPAGES];
  int       cyc = 0;
  int       n_chk = 0;
  int       n_fail = 0;
  bit       gc_seen = 1'b0;
  bit       done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: scoreboard pop and compare.
  always @(negedge clk) begin
    if (rst_n) begin
      if (gc_active) begin
        gc_seen = 1'b1;
        if (req_ready) check(1'b0, "R9", "ready during reclamation", 1, 0);
      end
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_err == e.err, "R4", "rsp_err", rsp_err, e.err);
          check(rsp_unmapped == e.unm, "R3", "rsp_unmapped", rsp_unmapped, e.unm);
          if (!e.wr || e.err)
            check(rsp_rdata == e.data, "R2", $sformatf("read data page %0d", e.addr),
                  rsp_rdata, e.data);
          check(cyc - e.acc == e.lat, "R10", "response latency", cyc - e.acc, e.lat);
        end
      end
    end
  end

  // Driver: called at a falling edge.
  task automatic send(input bit wr, input int a, input bit [7:0] d);
    exp_t e;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = 6'(a);
    req_wdata = d;
    e.wr   = wr;
    e.addr = a;
    e.err  = (a >= LPAGES);
    e.unm  = !e.err && !wr && !mdl_ok[a];
    e.data = (e.err || e.unm || wr) ? 8'hFF : mdl[a];
    e.acc  = cyc + 1;
    e.lat  = (wr && !e.err) ? PROG_CYC : 0;
    sb.push_back(e);
    if (wr && !e.err) begin
      mdl[a]    = d;
      mdl_ok[a] = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0 || !req_ready) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    req_valid = 1'b0;
    sb.delete();
    for (int i = 0; i < LPAGES; i++) begin
      mdl[i]    = 8'h00;
      mdl_ok[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n   = 1'b1;
    gc_seen = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", cyc, 0);
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset state
    check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    check(host_wr_cnt == 0, "R1", "host_wr_cnt", host_wr_cnt, 0);
    check(prog_cnt == 0, "R1", "prog_cnt", prog_cnt, 0);
    check(rsp_valid == 1'b0 && gc_active == 1'b0, "R1", "rsp_valid/gc_active",
          {rsp_valid, gc_active}, 0);

    // R3 unmapped, R2 write/overwrite, R4 rejects
    send(0, 10, 8'h00);
    send(1, 10, 8'h5A);
    send(0, 10, 8'h00);
    send(1, 10, 8'hC3);
    send(0, 10, 8'h00);
    send(1, 50, 8'h12);
    send(0, 63, 8'h00);
    send(0, 10, 8'h00);
    drain();
    check(host_wr_cnt == 2, "R5", "host count after rejects", host_wr_cnt, 2);
    check(prog_cnt == 2, "R4", "prog count after rejects", prog_cnt, 2);

    // Fully live drive, then one rewrite: exact amplification (R7)
    do_reset();
    for (int a = 0; a < LPAGES; a++) send(1, a, 8'(a * 5 + 7));
    drain();
    check(host_wr_cnt == 48, "R5", "host count fresh fill", host_wr_cnt, 48);
    check(prog_cnt == 48, "R6", "prog count equals host without copies", prog_cnt, 48);
    check(gc_seen == 1'b0, "R7", "no reclamation while spare block free", gc_seen, 0);
    send(1, 0, 8'hEE);
    drain();
    check(host_wr_cnt == 49, "R7", "host count after rewrite", host_wr_cnt, 49);
    check(prog_cnt == 64, "R7", "prog count with 15 copies", prog_cnt, 64);
    check(gc_seen == 1'b1, "R9", "reclamation observed", gc_seen, 1);
    for (int a = 0; a < LPAGES; a++) send(0, a, 8'h00);   // R8
    for (int i = 0; i < 60; i++) send(1, (i * 7 + 3) % LPAGES, 8'(i * 11 + 2));
    for (int a = 0; a < LPAGES; a++) send(0, a, 8'h00);   // R8
    drain();
    check(host_wr_cnt == 109, "R5", "host count after rewrites", host_wr_cnt, 109);
    check(prog_cnt > host_wr_cnt, "R6", "copies counted", prog_cnt, host_wr_cnt + 1);

    // Four passes over one block's worth: zero-copy reclamation (R11)
    do_reset();
    for (int pass = 0; pass < 4; pass++)
      for (int a = 0; a < 16; a++) send(1, a, 8'(pass * 16 + a));
    drain();
    check(host_wr_cnt == 64, "R11", "host count four passes", host_wr_cnt, 64);
    check(prog_cnt == 64, "R11", "prog count four passes", prog_cnt, 64);
    check(gc_seen == 1'b1, "R11", "reclamation observed", gc_seen, 1);
    for (int a = 0; a < 16; a++) send(0, a, 8'h00);       // R8
    send(0, 30, 8'h00);                                   // R3
    send(1, 20, 8'h3C);
    send(0, 20, 8'h00);
    drain();
    check(prog_cnt == 65, "R6", "prog count after new block write", prog_cnt, 65);

    finish_run();
  end

endmodule